// File: doc/BRIEF.md
# Combined Read-Modify-Write Opcode Unit

This unit computes the results of the undocumented combined instructions of an 8-bit accumulator processor. When the core has fetched the operand of such an instruction, it presents the opcode byte, that operand, the current A, X and S registers and the N, V, Z and C flags, and pulses `start`. One cycle later the unit returns a pulse on `done`. With it come the byte to write back to memory and its write strobe, the new A, X and S, and the new flags. Address generation and bus sequencing stay in the core. The unit only decides what is computed and which registers and memory change.

Most opcodes whose two low bits are both set run a memory-side operation on the operand first. This is a shift, a rotate, an increment or a decrement, and its result is written back. An accumulator-side operation then consumes that result. A few immediate-operand and transfer variants sit beside this scheme. The jam opcodes freeze the unit until reset. Any other opcode is reported as not handled and leaves all state as it was.

Top module: `rmw_combo_unit`

## Requirements
- R1: `done` rises exactly one cycle after an accepted `start`, with every result output valid in that cycle. `mem_we` and `unhandled` are high only in that cycle. A, X, S, flag and data outputs keep their values until the next accepted `start`.
- R2: For opcodes with bits[1:0]=11, bits[4:2]≠010 and bits[7:5] of 0, 1 or 2, the operand is shifted left, rotated left through C, or shifted right. The shifted value is written back. C takes the bit shifted out. The shifted value is then ORed, ANDed or XORed into A. N and Z follow the final A, and V is unchanged.
- R3: For bits[7:5]=3 (same columns), the operand is rotated right through C and written back. It is then added to A with the carry that the rotate produced, using binary arithmetic. C, V, N and Z come from the sum.
- R4: For bits[7:5]=6 (same columns), the operand is decremented and written back. A is compared against the new value: C=1 when A ≥ value, and N and Z follow A−value. A and V are unchanged.
- R5: For bits[7:5]=7 (same columns), the operand is incremented and written back. The new value is subtracted from A with borrow (borrow = not C), using binary arithmetic. C, V, N and Z come from the difference.
- R6: Opcodes 0x83, 0x87 and 0x93 write A AND X to memory and change no register or flag.
- R7: Opcodes 0xA3, 0xA7, 0xAF, 0xB3, 0xB7 and 0xBF load the operand into A and X and set N and Z from it, with no memory write.
- R8: Opcode 0xBB sets A, X and S to S AND operand, and sets N and Z from that value.
- R9: Immediate forms AND the operand into A first. For 0x0B and 0x2B, C then takes the top bit of the new A. For 0x4B, A is shifted right and C takes the bit shifted out. For 0x6B, A is rotated right through C and C takes the bit shifted out. N and Z follow the final A.
- R10: Opcode 0x8B sets A to X AND operand, and sets N and Z from it.
- R11: Opcodes with low nibble 2 and a high nibble of 0–7, 9, B, D or F jam the unit. `halted` rises and stays high. From then on `start` produces no `done` and no write until reset.
- R12: Any other opcode gives `done` with `unhandled` high and no write. A, X, S and all four flags equal their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, one cycle |
| opcode | input | 8 | Opcode byte |
| operand | input | W | Fetched memory or immediate operand |
| a_in | input | W | Current accumulator |
| x_in | input | W | Current X index |
| s_in | input | W | Current stack pointer |
| n_in | input | 1 | Current negative flag |
| v_in | input | 1 | Current overflow flag |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| mem_wdata | output | W | Byte to write back |
| mem_we | output | 1 | Write-back strobe |
| a_out | output | W | New accumulator |
| x_out | output | W | New X index |
| s_out | output | W | New stack pointer |
| n_out | output | 1 | New negative flag |
| v_out | output | 1 | New overflow flag |
| z_out | output | 1 | New zero flag |
| c_out | output | 1 | New carry flag |
| done | output | 1 | Result valid pulse |
| unhandled | output | 1 | Opcode not in the handled set |
| halted | output | 1 | Unit jammed until reset |

## Verification
The bench builds the unit with its default data width W=8. That width is what gives the opcode groups their meaning, and it makes 0x80 and 0x7F the signed overflow corners. At this width, adder overflow and borrow, a decrement that wraps from 0x00 to 0xFF, and carry taken out of both ends of the byte can all be reached with hand-chosen operands. The jam case runs last and is followed by a reset, so both the stuck state and the recovery from it are observed at the ports.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_RMW, K_SAX, K_LAX, K_LAS, K_ANC, K_ALR, K_ARR, K_XAA, K_JAM
    } kind_e;

    typedef enum logic [2:0] {
        MOP_PASS, MOP_ASL, MOP_ROL, MOP_LSR, MOP_ROR, MOP_DEC, MOP_INC
    } mem_op_e;

    typedef enum logic [2:0] {
        AOP_NONE, AOP_OR, AOP_AND, AOP_EOR, AOP_ADC, AOP_CMP, AOP_SBC
    } acc_op_e;

    typedef struct packed {
        kind_e   kind;
        mem_op_e mop;
        acc_op_e aop;
    } dec_t;

endpackage

// File: rtl/rmw_decode.sv
module rmw_decode
    import rmw_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    logic [2:0] grp;
    logic [2:0] col;

    assign grp = opcode[7:5];
    assign col = opcode[4:2];

    always_comb begin
        dec = '{kind: K_NONE, mop: MOP_PASS, aop: AOP_NONE};
        if (opcode[3:0] == 4'h2 && (!opcode[7] || opcode[4])) begin
            dec.kind = K_JAM;
        end else if (opcode[1:0] == 2'b11) begin
            if (col == 3'b010) begin
                case (opcode)
                    8'h0B, 8'h2B: dec.kind = K_ANC;
                    8'h4B:        dec.kind = K_ALR;
                    8'h6B:        dec.kind = K_ARR;
                    8'h8B:        dec.kind = K_XAA;
                    default:      dec.kind = K_NONE;
                endcase
            end else begin
                case (grp)
                    3'd0: dec = '{kind: K_RMW, mop: MOP_ASL, aop: AOP_OR};
                    3'd1: dec = '{kind: K_RMW, mop: MOP_ROL, aop: AOP_AND};
                    3'd2: dec = '{kind: K_RMW, mop: MOP_LSR, aop: AOP_EOR};
                    3'd3: dec = '{kind: K_RMW, mop: MOP_ROR, aop: AOP_ADC};
                    3'd4: if (opcode == 8'h83 || opcode == 8'h87 || opcode == 8'h93)
                              dec.kind = K_SAX;
                    3'd5: dec.kind = (col == 3'b110) ? K_LAS : K_LAX;
                    3'd6: dec = '{kind: K_RMW, mop: MOP_DEC, aop: AOP_CMP};
                    default: dec = '{kind: K_RMW, mop: MOP_INC, aop: AOP_SBC};
                endcase
            end
        end
    end
endmodule

// File: rtl/rmw_mem_stage.sv
module rmw_mem_stage
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  mem_op_e      mop,
    input  logic [W-1:0] din,
    input  logic         cin,
    output logic [W-1:0] dout,
    output logic         cout
);
    always_comb begin
        dout = din;
        cout = cin;
        case (mop)
            MOP_ASL: begin dout = {din[W-2:0], 1'b0}; cout = din[W-1]; end
            MOP_ROL: begin dout = {din[W-2:0], cin};  cout = din[W-1]; end
            MOP_LSR: begin dout = {1'b0, din[W-1:1]}; cout = din[0];   end
            MOP_ROR: begin dout = {cin, din[W-1:1]};  cout = din[0];   end
            MOP_DEC: dout = din - 1'b1;
            MOP_INC: dout = din + 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_acc_stage.sv
module rmw_acc_stage
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  acc_op_e      aop,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] m,
    input  logic         cin,
    input  logic         vin,
    output logic [W-1:0] acc_new,
    output logic [W-1:0] flag_val,
    output logic         cout,
    output logic         vout
);
    logic [W:0]   sum;
    logic [W-1:0] addend;
    logic         carry_in;

    always_comb begin
        addend   = (aop == AOP_ADC) ? m : ~m;
        carry_in = (aop == AOP_CMP) ? 1'b1 : cin;
        sum      = {1'b0, acc} + {1'b0, addend} + {{W{1'b0}}, carry_in};
    end

    always_comb begin
        acc_new = acc;
        cout    = cin;
        vout    = vin;
        case (aop)
            AOP_OR:  acc_new = acc | m;
            AOP_AND: acc_new = acc & m;
            AOP_EOR: acc_new = acc ^ m;
            AOP_ADC, AOP_SBC: begin
                acc_new = sum[W-1:0];
                cout    = sum[W];
                vout    = (acc[W-1] == addend[W-1]) && (sum[W-1] != acc[W-1]);
            end
            AOP_CMP: cout = sum[W];
            default: ;
        endcase
        flag_val = (aop == AOP_CMP) ? sum[W-1:0] : acc_new;
    end
endmodule

// File: rtl/rmw_combo_unit.sv
module rmw_combo_unit
    import rmw_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] s_in,
    input  logic         n_in,
    input  logic         v_in,
    input  logic         z_in,
    input  logic         c_in,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    output logic [W-1:0] a_out,
    output logic [W-1:0] x_out,
    output logic [W-1:0] s_out,
    output logic         n_out,
    output logic         v_out,
    output logic         z_out,
    output logic         c_out,
    output logic         done,
    output logic         unhandled,
    output logic         halted
);
    typedef struct packed {
        logic [W-1:0] mem;
        logic         we;
        logic [W-1:0] a;
        logic [W-1:0] x;
        logic [W-1:0] s;
        logic         n, v, z, c;
        logic         done;
        logic         unh;
        logic         halt;
    } st_t;

    st_t st_d, st_q;
    dec_t dec;

    logic [W-1:0] m_res, acc_res, acc_flag;
    logic         m_c, acc_c, acc_v;
    logic [W-1:0] t_and;

    rmw_decode u_dec (.opcode(opcode), .dec(dec));

    rmw_mem_stage #(.W(W)) u_mem (
        .mop(dec.mop), .din(operand), .cin(c_in), .dout(m_res), .cout(m_c)
    );

    rmw_acc_stage #(.W(W)) u_acc (
        .aop(dec.aop), .acc(a_in), .m(m_res), .cin(m_c), .vin(v_in),
        .acc_new(acc_res), .flag_val(acc_flag), .cout(acc_c), .vout(acc_v)
    );

    assign t_and = a_in & operand;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        st_d.unh  = 1'b0;
        if (start && !st_q.halt) begin
            st_d.done = 1'b1;
            st_d.mem  = operand;
            st_d.a    = a_in;
            st_d.x    = x_in;
            st_d.s    = s_in;
            st_d.n    = n_in;
            st_d.v    = v_in;
            st_d.z    = z_in;
            st_d.c    = c_in;
            case (dec.kind)
                K_RMW: begin
                    st_d.mem = m_res;
                    st_d.we  = 1'b1;
                    st_d.a   = acc_res;
                    st_d.c   = acc_c;
                    st_d.v   = acc_v;
                    st_d.n   = acc_flag[W-1];
                    st_d.z   = (acc_flag == '0);
                end
                K_SAX: begin
                    st_d.mem = a_in & x_in;
                    st_d.we  = 1'b1;
                end
                K_LAX: begin
                    st_d.a = operand;
                    st_d.x = operand;
                end
                K_LAS: begin
                    st_d.a = s_in & operand;
                    st_d.x = s_in & operand;
                    st_d.s = s_in & operand;
                end
                K_ANC: begin
                    st_d.a = t_and;
                    st_d.c = t_and[W-1];
                end
                K_ALR: begin
                    st_d.a = {1'b0, t_and[W-1:1]};
                    st_d.c = t_and[0];
                end
                K_ARR: begin
                    st_d.a = {c_in, t_and[W-1:1]};
                    st_d.c = t_and[0];
                end
                K_XAA: st_d.a = x_in & operand;
                K_JAM: begin
                    st_d.done = 1'b0;
                    st_d.halt = 1'b1;
                end
                default: st_d.unh = 1'b1;
            endcase
            if (dec.kind inside {K_LAX, K_LAS, K_ANC, K_ALR, K_ARR, K_XAA}) begin
                st_d.n = st_d.a[W-1];
                st_d.z = (st_d.a == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_wdata = st_q.mem;
    assign mem_we    = st_q.we;
    assign a_out     = st_q.a;
    assign x_out     = st_q.x;
    assign s_out     = st_q.s;
    assign n_out     = st_q.n;
    assign v_out     = st_q.v;
    assign z_out     = st_q.z;
    assign c_out     = st_q.c;
    assign done      = st_q.done;
    assign unhandled = st_q.unh;
    assign halted    = st_q.halt;
endmodule

// File: rtl/rmw_combo_unit_chk.sv
module rmw_combo_unit_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic         mem_we,
    input logic         unhandled,
    input logic         halted,
    input logic [W-1:0] a_out
);
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(start)); // R1
    AST_WE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> done); // R1
    AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(a_out)); // R1
    AST_UNHANDLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) unhandled |-> (done && !mem_we)); // R12
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R11
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) halted |-> (!done && !mem_we)); // R11
endmodule

bind rmw_combo_unit rmw_combo_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .mem_we(mem_we),
    .unhandled(unhandled), .halted(halted), .a_out(a_out)
);

// File: tb/rmw_combo_unit_tb.sv
module rmw_combo_unit_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   opcode = '0;
    logic [W-1:0] operand = '0, a_in = '0, x_in = '0, s_in = '0;
    logic         n_in = 1'b0, v_in = 1'b0, z_in = 1'b0, c_in = 1'b0;
    logic [W-1:0] mem_wdata, a_out, x_out, s_out;
    logic         mem_we, n_out, v_out, z_out, c_out, done, unhandled, halted;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rmw_combo_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .a_in(a_in), .x_in(x_in), .s_in(s_in), .n_in(n_in), .v_in(v_in), .z_in(z_in),
        .c_in(c_in), .mem_wdata(mem_wdata), .mem_we(mem_we), .a_out(a_out), .x_out(x_out),
        .s_out(s_out), .n_out(n_out), .v_out(v_out), .z_out(z_out), .c_out(c_out),
        .done(done), .unhandled(unhandled), .halted(halted)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // flags argument packed as {n,v,z,c}
    task automatic issue(input logic [7:0] op, input logic [W-1:0] opd, input logic [W-1:0] a,
                         input logic [W-1:0] x, input logic [W-1:0] s, input logic [3:0] f);
        @(negedge clk);
        opcode = op; operand = opd; a_in = a; x_in = x; s_in = s;
        {n_in, v_in, z_in, c_in} = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic we, input logic [W-1:0] mem,
                              input logic [W-1:0] a, input logic [W-1:0] x,
                              input logic [W-1:0] s, input logic [3:0] f);
        chk({tag, " done"}, done, 1'b1);
        chk({tag, " we"}, mem_we, we);
        if (we) chk({tag, " mem"}, mem_wdata, mem);
        chk({tag, " a"}, a_out, a);
        chk({tag, " x"}, x_out, x);
        chk({tag, " s"}, s_out, s);
        chk({tag, " nvzc"}, {n_out, v_out, z_out, c_out}, f);
        chk({tag, " unhandled"}, unhandled, 1'b0);
    endtask

    task automatic t_reset_state();
        chk("reset done", done, 1'b0);
        chk("reset we", mem_we, 1'b0);
        chk("reset halted", halted, 1'b0);
    endtask

    task automatic t_timing_r1();
        issue(8'h07, 8'h81, 8'h10, 8'h00, 8'hFF, 4'b0000);
        expect_all("R1/R2 asl-ora", 1'b1, 8'h02, 8'h12, 8'h00, 8'hFF, 4'b0001);
        a_in = 8'h55; operand = 8'h00;
        @(negedge clk);
        chk("R1 done pulse ends", done, 1'b0);
        chk("R1 we pulse ends", mem_we, 1'b0);
        chk("R1 a held", a_out, 8'h12);
    endtask

    task automatic t_shift_logic_r2();
        issue(8'h27, 8'hC3, 8'hF0, 8'h01, 8'h02, 4'b0101);
        expect_all("R2 rol-and", 1'b1, 8'h87, 8'h80, 8'h01, 8'h02, 4'b1101);
        issue(8'h47, 8'h03, 8'h01, 8'h01, 8'h02, 4'b0000);
        expect_all("R2 lsr-eor", 1'b1, 8'h01, 8'h00, 8'h01, 8'h02, 4'b0011);
    endtask

    task automatic t_ror_adc_r3();
        issue(8'h67, 8'h01, 8'h7F, 8'h00, 8'h00, 4'b0000);
        expect_all("R3 ror-adc overflow", 1'b1, 8'h00, 8'h80, 8'h00, 8'h00, 4'b1100);
        issue(8'h77, 8'hFE, 8'h01, 8'h00, 8'h00, 4'b0001);
        expect_all("R3 ror-adc carry", 1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 4'b0011);
    endtask

    task automatic t_dec_cmp_r4();
        issue(8'hC7, 8'h00, 8'h10, 8'h00, 8'h00, 4'b0100);
        expect_all("R4 dec wraps", 1'b1, 8'hFF, 8'h10, 8'h00, 8'h00, 4'b0100);
        issue(8'hCF, 8'h11, 8'h10, 8'h00, 8'h00, 4'b0000);
        expect_all("R4 dec equal", 1'b1, 8'h10, 8'h10, 8'h00, 8'h00, 4'b0011);
    endtask

    task automatic t_inc_sbc_r5();
        issue(8'hE7, 8'h0F, 8'h30, 8'h00, 8'h00, 4'b0001);
        expect_all("R5 inc-sbc no borrow", 1'b1, 8'h10, 8'h20, 8'h00, 8'h00, 4'b0001);
        issue(8'hE7, 8'h0F, 8'h30, 8'h00, 8'h00, 4'b0000);
        expect_all("R5 inc-sbc borrow in", 1'b1, 8'h10, 8'h1F, 8'h00, 8'h00, 4'b0001);
        issue(8'hFF, 8'h00, 8'h80, 8'h00, 8'h00, 4'b0001);
        expect_all("R5 inc-sbc overflow", 1'b1, 8'h01, 8'h7F, 8'h00, 8'h00, 4'b0101);
    endtask

    task automatic t_store_and_r6();
        issue(8'h87, 8'h99, 8'hF0, 8'h3C, 8'h11, 4'b1111);
        expect_all("R6 store a&x", 1'b1, 8'h30, 8'hF0, 8'h3C, 8'h11, 4'b1111);
    endtask

    task automatic t_load_both_r7();
        issue(8'hA7, 8'h00, 8'h5A, 8'hA5, 8'h11, 4'b1000);
        expect_all("R7 load zero", 1'b0, 8'h00, 8'h00, 8'h00, 8'h11, 4'b0010);
        issue(8'hBF, 8'h80, 8'h5A, 8'hA5, 8'h11, 4'b0010);
        expect_all("R7 load neg", 1'b0, 8'h00, 8'h80, 8'h80, 8'h11, 4'b1000);
    endtask

    task automatic t_stack_and_r8();
        issue(8'hBB, 8'h5F, 8'h00, 8'h00, 8'hF3, 4'b0000);
        expect_all("R8 s&operand", 1'b0, 8'h00, 8'h53, 8'h53, 8'h53, 4'b0000);
    endtask

    task automatic t_immediate_r9();
        issue(8'h0B, 8'h80, 8'hFF, 8'h00, 8'h00, 4'b0000);
        expect_all("R9 and-carry 0B", 1'b0, 8'h00, 8'h80, 8'h00, 8'h00, 4'b1001);
        issue(8'h2B, 8'hFF, 8'h7F, 8'h00, 8'h00, 4'b0001);
        expect_all("R9 and-carry 2B", 1'b0, 8'h00, 8'h7F, 8'h00, 8'h00, 4'b0000);
        issue(8'h4B, 8'h03, 8'hFF, 8'h00, 8'h00, 4'b0000);
        expect_all("R9 and-shift", 1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 4'b0001);
        issue(8'h6B, 8'h02, 8'hFF, 8'h00, 8'h00, 4'b0001);
        expect_all("R9 and-rotate", 1'b0, 8'h00, 8'h81, 8'h00, 8'h00, 4'b1000);
    endtask

    task automatic t_xfer_and_r10();
        issue(8'h8B, 8'hFC, 8'hAA, 8'h0F, 8'h00, 4'b0000);
        expect_all("R10 x&imm", 1'b0, 8'h00, 8'h0C, 8'h0F, 8'h00, 4'b0000);
    endtask

    task automatic t_unhandled_r12();
        issue(8'hEB, 8'h12, 8'h34, 8'h56, 8'h78, 4'b1010);
        chk("R12 done", done, 1'b1);
        chk("R12 unhandled", unhandled, 1'b1);
        chk("R12 no write", mem_we, 1'b0);
        chk("R12 a", a_out, 8'h34);
        chk("R12 x", x_out, 8'h56);
        chk("R12 s", s_out, 8'h78);
        chk("R12 flags", {n_out, v_out, z_out, c_out}, 4'b1010);
        issue(8'h8F, 8'h12, 8'h34, 8'h56, 8'h78, 4'b0101);
        chk("R12 8F unhandled", unhandled, 1'b1);
        chk("R12 8F no write", mem_we, 1'b0);
    endtask

    task automatic t_jam_r11();
        issue(8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0000);
        chk("R11 no done on jam", done, 1'b0);
        chk("R11 halted", halted, 1'b1);
        issue(8'h07, 8'h81, 8'h10, 8'h00, 8'h00, 4'b0000);
        chk("R11 start ignored", done, 1'b0);
        chk("R11 no write", mem_we, 1'b0);
        chk("R11 still halted", halted, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 reset clears halt", halted, 1'b0);
        issue(8'hF2, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0000);
        chk("R11 F2 jams", halted, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        issue(8'hA7, 8'h42, 8'h00, 8'h00, 8'h00, 4'b0000);
        chk("R11 runs after reset", a_out, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_timing_r1();
        t_shift_logic_r2();
        t_ror_adc_r3();
        t_dec_cmp_r4();
        t_inc_sbc_r5();
        t_store_and_r6();
        t_load_both_r7();
        t_stack_and_r8();
        t_immediate_r9();
        t_xfer_and_r10();
        t_unhandled_r12();
        t_jam_r11();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule